// File: doc/BRIEF.md
# UART Receive Path with Line Status

This block is the receive half of an asynchronous serial port. It deserializes a line that is sampled at sixteen times the bit rate, checks each character for parity, framing and break conditions, and holds received characters either in a single holding register or in a sixteen-entry receive queue. Each queue entry keeps its three error flags beside its data byte. The host sees a line status byte. Flags belonging to a character appear in that byte only once the character reaches the read end of the queue.

Received characters leave through a valid/ready port. `rx_valid` is high while a character is waiting. `rx_data` holds still until the cycle in which `rx_ready` is also high, and that cycle removes the character. The block has no other back-pressure toward the line. A character that completes while storage is full is dropped and recorded as an overrun. Status is read with a one-cycle `rd_status` strobe, which clears the sticky bits. The transmit half is not part of this block. It only provides its holding-empty and shifter-idle levels, and these are shown in the status byte.

Top module: `uart_rx_lsr`

## Requirements
- R1: A character starts with a falling edge that is still low at the mid-bit sample, eight `os_tick` pulses later. It then carries `cfg_wlen`+5 data bits, LSB first, one parity bit when `cfg_par_en` is 1, and one stop bit. Each bit lasts 16 `os_tick` pulses. Data bits above the configured length read as 0.
- R2: With parity on, the parity error flag is raised when the count of ones over data and parity is odd (`cfg_par_even`=1) or even (`cfg_par_even`=0).
- R3: A 0 in the stop position raises the framing error flag. One bit time later the line is sampled again. A 0 there is taken as the start bit of a new character, and a 1 returns the receiver to idle.
- R4: When data, parity and stop bits are all 0, exactly one character is stored, with data 0x00, the break flag set and the parity and framing flags clear. No further character is received until the line has been high and a new start bit arrives.
- R5: `rx_valid` stays high and `rx_data` stays constant until a cycle with `rx_valid` and `rx_ready` both high. That cycle removes the character.
- R6: In queue mode (`cfg_fifo_en`=1, `cfg_legacy`=0) up to 16 characters are held in arrival order. A character that completes while all 16 are held is dropped, the queue is left unchanged, and status bit 1 (overrun) is set.
- R7: In single-register mode (`cfg_fifo_en`=0 or `cfg_legacy`=1) one character is held. A character that completes while it is unread is dropped, the held one is kept, and status bit 1 is set.
- R8: Status bits 2 (parity), 3 (framing) and 4 (break) take their values from the character at the read end. They are raised one cycle after that character becomes the head, and not while it is still behind other entries.
- R9: A cycle with `rd_status` high clears status bits 1, 2, 3, 4 and 7. A flag of a head that was already reported is not raised again. A new event in the same cycle wins over the clear.
- R10: Status bit 7 is set when a flagged character enters the queue in queue mode. It is cleared by a status read, or when no flagged entry remains. It is always 0 in single-register mode.
- R11: Status bit 5 equals `tx_hold_empty`. Status bit 6 equals `tx_hold_empty` AND `tx_shift_idle`.
- R12: Status bit 0 equals `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_serial | input | 1 | Serial receive line, idle high |
| os_tick | input | 1 | Oversampling enable, 16 per bit |
| cfg_wlen | input | 2 | Data length code: 0..3 gives 5..8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 even parity, 0 odd parity |
| cfg_fifo_en | input | 1 | Select the 16-entry queue |
| cfg_legacy | input | 1 | Force single-register operation |
| rd_status | input | 1 | Status read strobe, clears sticky bits |
| tx_hold_empty | input | 1 | Transmit holding storage empty |
| tx_shift_idle | input | 1 | Transmit shifter idle |
| rx_valid | output | 1 | Received character available |
| rx_ready | input | 1 | Host takes the character |
| rx_data | output | 8 | Character at the read end |
| lsr | output | 8 | Line status byte, bit positions per R6 to R12 |

## Verification
The assertions check on every cycle that a waiting character holds still until it is taken, that a character arriving into full storage always leaves the overrun bit set, that a detected break always yields an all-zero, break-only word, that a status read without a simultaneous overrun leaves the overrun bit clear, and that transmitter-empty never shows without transmitter-ready. Other behaviours only show up through the bench's scenarios. These are the resynchronisation after a bad stop bit, holding back a queued character's flags until it reaches the head, the single character from a long low line, the word-length and parity variants, and the summary bit tracking flagged entries as they drain.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int RX_DATA_W = 8;

  typedef struct packed {
    logic                 brk;
    logic                 frm_err;
    logic                 par_err;
    logic [RX_DATA_W-1:0] data;
  } rx_char_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_RESYNC, S_BRKWAIT
  } rx_state_e;

  function automatic logic has_flag(rx_char_t c);
    return c.brk | c.frm_err | c.par_err;
  endfunction
endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rx_serial,
  input  logic     os_tick,
  input  logic [1:0] cfg_wlen,
  input  logic     cfg_par_en,
  input  logic     cfg_par_even,
  output logic     char_valid,
  output rx_char_t char_word
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(RX_DATA_W);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

  logic [1:0]           sync_q;
  logic                 rx_s;
  rx_state_e            state;
  logic [CNT_W-1:0]     cnt;
  logic [IDX_W-1:0]     idx;
  logic [IDX_W-1:0]     last_idx;
  logic [RX_DATA_W-1:0] shreg;
  logic                 all_zero;
  logic                 par_bad;
  logic                 bit_edge;

  assign rx_s     = sync_q[1];
  assign last_idx = IDX_W'(RX_DATA_W - 4) + IDX_W'(cfg_wlen);
  assign bit_edge = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= 2'b11;
      state      <= S_IDLE;
      cnt        <= '0;
      idx        <= '0;
      shreg      <= '0;
      all_zero   <= 1'b0;
      par_bad    <= 1'b0;
      char_valid <= 1'b0;
      char_word  <= '0;
    end else begin
      sync_q     <= {sync_q[0], rx_serial};
      char_valid <= 1'b0;
      if (os_tick) begin
        unique case (state)
          S_IDLE: if (!rx_s) begin
            state <= S_START;
            cnt   <= '0;
          end
          S_START: begin
            if (cnt == MID) begin
              cnt <= '0;
              if (!rx_s) begin
                state    <= S_DATA;
                idx      <= '0;
                shreg    <= '0;
                all_zero <= 1'b1;
                par_bad  <= 1'b0;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (bit_edge) begin
              cnt        <= '0;
              shreg[idx] <= rx_s;
              all_zero   <= all_zero & ~rx_s;
              if (idx == last_idx) state <= cfg_par_en ? S_PAR : S_STOP;
              else                 idx   <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_PAR: begin
            if (bit_edge) begin
              cnt      <= '0;
              par_bad  <= (^shreg) ^ rx_s ^ ~cfg_par_even;
              all_zero <= all_zero & ~rx_s;
              state    <= S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (bit_edge) begin
              cnt        <= '0;
              char_valid <= 1'b1;
              if (!rx_s && all_zero) begin
                char_word <= '{brk: 1'b1, frm_err: 1'b0, par_err: 1'b0, data: '0};
                state     <= S_BRKWAIT;
              end else begin
                char_word <= '{brk: 1'b0, frm_err: ~rx_s, par_err: par_bad, data: shreg};
                state     <= rx_s ? S_IDLE : S_RESYNC;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_RESYNC: begin
            if (bit_edge) begin
              cnt <= '0;
              if (!rx_s) begin
                state    <= S_DATA;
                idx      <= '0;
                shreg    <= '0;
                all_zero <= 1'b1;
                par_bad  <= 1'b0;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_BRKWAIT: if (rx_s) state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             single_mode,
  input  logic             push_valid,
  input  rx_char_t         push_word,
  output logic             full,
  input  logic             pop_ready,
  output logic             pop_valid,
  output rx_char_t         pop_word,
  output logic [CNT_W-1:0] flag_cnt
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  rx_char_t         mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop, push_f, pop_f;

  assign full      = single_mode ? (count != '0) : (count == CNT_W'(DEPTH));
  assign pop_valid = (count != '0);
  assign pop_word  = mem[rd_ptr];
  assign do_push   = push_valid & ~full;
  assign do_pop    = pop_ready & pop_valid;
  assign push_f    = do_push & has_flag(push_word);
  assign pop_f     = do_pop & has_flag(pop_word);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      flag_cnt <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      unique case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      unique case ({push_f, pop_f})
        2'b10:   flag_cnt <= flag_cnt + 1'b1;
        2'b01:   flag_cnt <= flag_cnt - 1'b1;
        default: flag_cnt <= flag_cnt;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
  import uart_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int OVERSAMPLE = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_serial,
  input  logic                 os_tick,
  input  logic [1:0]           cfg_wlen,
  input  logic                 cfg_par_en,
  input  logic                 cfg_par_even,
  input  logic                 cfg_fifo_en,
  input  logic                 cfg_legacy,
  input  logic                 rd_status,
  input  logic                 tx_hold_empty,
  input  logic                 tx_shift_idle,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic [RX_DATA_W-1:0] rx_data,
  output logic [7:0]           lsr
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic             char_valid;
  rx_char_t         char_word;
  logic             fifo_full;
  rx_char_t         head;
  logic [CNT_W-1:0] flag_cnt;
  logic             queue_mode;
  logic             push_ok, pop, new_head;
  logic             head_seen;
  logic             st_ovr, st_pe, st_fe, st_brk, st_erf;

  assign queue_mode = cfg_fifo_en & ~cfg_legacy;

  uart_rx_deser #(.OVERSAMPLE(OVERSAMPLE)) u_deser (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_serial   (rx_serial),
    .os_tick     (os_tick),
    .cfg_wlen    (cfg_wlen),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_even(cfg_par_even),
    .char_valid  (char_valid),
    .char_word   (char_word)
  );

  uart_rx_fifo #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .single_mode(~queue_mode),
    .push_valid (char_valid),
    .push_word  (char_word),
    .full       (fifo_full),
    .pop_ready  (rx_ready),
    .pop_valid  (rx_valid),
    .pop_word   (head),
    .flag_cnt   (flag_cnt)
  );

  assign push_ok  = char_valid & ~fifo_full;
  assign pop      = rx_valid & rx_ready;
  assign new_head = rx_valid & ~head_seen;
  assign rx_data  = head.data;

  // R8/R9: head flags are reported once, sticky until a status read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_seen <= 1'b0;
      st_ovr    <= 1'b0;
      st_pe     <= 1'b0;
      st_fe     <= 1'b0;
      st_brk    <= 1'b0;
      st_erf    <= 1'b0;
    end else begin
      if (pop)           head_seen <= 1'b0;
      else if (rx_valid) head_seen <= 1'b1;
      st_ovr <= (st_ovr & ~rd_status) | (char_valid & fifo_full);
      st_pe  <= (st_pe  & ~rd_status) | (new_head & head.par_err);
      st_fe  <= (st_fe  & ~rd_status) | (new_head & head.frm_err);
      st_brk <= (st_brk & ~rd_status) | (new_head & head.brk);
      st_erf <= (st_erf & ~rd_status) | (push_ok & queue_mode & has_flag(char_word));
    end
  end

  assign lsr = {st_erf & queue_mode & (flag_cnt != '0),
                tx_hold_empty & tx_shift_idle,
                tx_hold_empty,
                st_brk, st_fe, st_pe, st_ovr,
                rx_valid};
endmodule

// File: rtl/uart_rx_lsr_chk.sv
module uart_rx_lsr_chk
  import uart_rx_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rx_valid,
  input logic                 rx_ready,
  input logic [RX_DATA_W-1:0] rx_data,
  input logic                 rd_status,
  input logic                 ovr_flag,
  input logic                 txrdy_flag,
  input logic                 txemp_flag,
  input logic                 char_valid,
  input rx_char_t             char_word,
  input logic                 fifo_full
);
  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data)); // R5

  AST_OVERRUN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid && fifo_full |=> ovr_flag); // R6

  AST_OVERRUN_KEEPS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid && fifo_full && rx_valid && !rx_ready |=> $stable(rx_data)); // R7

  AST_BREAK_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid && char_word.brk |-> char_word.data == '0 && !char_word.frm_err && !char_word.par_err); // R4

  AST_READ_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status && !(char_valid && fifo_full) |=> !ovr_flag); // R9

  AST_TXEMP_NEEDS_TXRDY: assert property (@(posedge clk) disable iff (!rst_n)
    txemp_flag |-> txrdy_flag); // R11
endmodule

bind uart_rx_lsr uart_rx_lsr_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .rx_data   (rx_data),
  .rd_status (rd_status),
  .ovr_flag  (lsr[1]),
  .txrdy_flag(lsr[5]),
  .txemp_flag(lsr[6]),
  .char_valid(char_valid),
  .char_word (char_word),
  .fifo_full (fifo_full)
);

// File: tb/uart_rx_lsr_tb.sv
module uart_rx_lsr_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_serial = 1'b1;
  logic       os_tick = 1'b1;
  logic [1:0] cfg_wlen = 2'd3;
  logic       cfg_par_en = 1'b0, cfg_par_even = 1'b1;
  logic       cfg_fifo_en = 1'b0, cfg_legacy = 1'b0;
  logic       rd_status = 1'b0, rx_ready = 1'b0;
  logic       tx_hold_empty = 1'b1, tx_shift_idle = 1'b1;
  logic       rx_valid;
  logic [7:0] rx_data, lsr;

  always #5ns clk = ~clk;

  uart_rx_lsr u_dut (.*);

  int vectors = 0, miscompares = 0, quiet = 0;
  bit in_frame = 1'b0;
  logic [10:0] mq[$];           // {brk, fe, pe, data}
  bit m_ovr, m_pe, m_fe, m_brk, m_erf, m_seen;

  function automatic bit fifo_mode();
    return cfg_fifo_en && !cfg_legacy;
  endfunction

  function automatic void cmp(string req, string what, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endfunction

  function automatic void model_head();
    if (mq.size() != 0 && !m_seen) begin
      m_pe |= mq[0][8]; m_fe |= mq[0][9]; m_brk |= mq[0][10]; m_seen = 1'b1;
    end
  endfunction

  function automatic void model_push(logic [10:0] c);
    int cap = fifo_mode() ? 16 : 1;
    if (mq.size() >= cap) m_ovr = 1'b1;
    else begin
      mq.push_back(c);
      if (fifo_mode() && |c[10:8]) m_erf = 1'b1;
    end
    model_head();
  endfunction

  function automatic void model_pop();
    if (mq.size() != 0) begin
      void'(mq.pop_front());
      m_seen = 1'b0;
      model_head();
    end
  endfunction

  function automatic void compare_all();
    logic [7:0] e;
    bit anyflag = 1'b0;
    foreach (mq[i]) if (|mq[i][10:8]) anyflag = 1'b1;
    e[0] = (mq.size() != 0);
    e[1] = m_ovr; e[2] = m_pe; e[3] = m_fe; e[4] = m_brk;
    e[5] = tx_hold_empty;
    e[6] = tx_hold_empty & tx_shift_idle;
    e[7] = fifo_mode() && m_erf && anyflag;
    cmp("R5", "rx_valid", {7'd0, rx_valid}, {7'd0, e[0]});
    cmp("R12", "ready bit", {7'd0, lsr[0]}, {7'd0, e[0]});
    cmp("R6 R7 R9", "overrun bit", {7'd0, lsr[1]}, {7'd0, e[1]});
    cmp("R2 R8", "parity bit", {7'd0, lsr[2]}, {7'd0, e[2]});
    cmp("R3 R8", "framing bit", {7'd0, lsr[3]}, {7'd0, e[3]});
    cmp("R4 R8", "break bit", {7'd0, lsr[4]}, {7'd0, e[4]});
    cmp("R11", "tx bits", {6'd0, lsr[6:5]}, {6'd0, e[6:5]});
    cmp("R10 R9", "queue error bit", {7'd0, lsr[7]}, {7'd0, e[7]});
    if (mq.size() != 0) cmp("R1 R5", "rx_data", rx_data, mq[0][7:0]);
  endfunction

  task automatic step();
    @(negedge clk);
    if (quiet > 0) quiet--;
    else if (!in_frame) compare_all();
  endtask

  task automatic drive_bit(input logic b);
    rx_serial = b;
    repeat (16) step();
  endtask

  function automatic logic [7:0] wmask();
    return 8'((1 << (5 + int'(cfg_wlen))) - 1);
  endfunction

  function automatic logic [10:0] entry(input logic [7:0] d, input bit flip, input bit stopb);
    return {1'b0, ~stopb, cfg_par_en & flip, d & wmask()};
  endfunction

  task automatic send_frame(input logic [7:0] d, input bit flip, input bit stopb);
    logic p;
    drive_bit(1'b0);
    for (int i = 0; i < 5 + int'(cfg_wlen); i++) drive_bit(d[i]);
    if (cfg_par_en) begin
      p = ^(d & wmask());
      if (!cfg_par_even) p = ~p;
      if (flip) p = ~p;
      drive_bit(p);
    end
    drive_bit(stopb);
  endtask

  task automatic one_char(input logic [7:0] d, input bit flip, input bit stopb);
    in_frame = 1'b1;
    send_frame(d, flip, stopb);
    drive_bit(1'b1);
    model_push(entry(d, flip, stopb));
    in_frame = 1'b0;
    quiet = 1;
    repeat (2) step();
  endtask

  task automatic read_data();
    rx_ready = 1'b1;
    model_pop();
    quiet = 2;
    step();
    rx_ready = 1'b0;
    repeat (2) step();
  endtask

  task automatic read_status();
    rd_status = 1'b1;
    m_ovr = 0; m_pe = 0; m_fe = 0; m_brk = 0; m_erf = 0;
    step();
    rd_status = 1'b0;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual still running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    quiet = 4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();                     // reset state: R12 R11

    // single register, 8N1: R1 R5
    one_char(8'hA5, 0, 1);
    read_data();
    // single register overrun: R7
    one_char(8'h3C, 0, 1);
    one_char(8'hC3, 0, 1);
    read_status();
    read_data();

    // 7 bits, even parity, then odd parity: R2
    cfg_wlen = 2'd2; cfg_par_en = 1'b1; cfg_par_even = 1'b1;
    one_char(8'h55, 0, 1); read_data();
    one_char(8'h2A, 1, 1); read_status(); read_data();
    cfg_par_even = 1'b0;
    one_char(8'h0F, 0, 1); read_data();
    one_char(8'h70, 1, 1); read_status(); read_data();

    // 5 bits, no parity: R1
    cfg_wlen = 2'd0; cfg_par_en = 1'b0;
    one_char(8'hFB, 0, 1); read_data();

    // queue mode, framing error then idle: R3
    cfg_wlen = 2'd3; cfg_fifo_en = 1'b1;
    one_char(8'h81, 0, 0);
    one_char(8'h42, 0, 1);
    read_status(); read_data(); read_data();

    // framing error followed at once by a start bit: R3 resync
    in_frame = 1'b1;
    send_frame(8'h99, 0, 0);
    send_frame(8'h66, 0, 1);
    drive_bit(1'b1);
    model_push(entry(8'h99, 0, 0));
    model_push(entry(8'h66, 0, 1));
    in_frame = 1'b0; quiet = 1;
    repeat (2) step();
    read_status(); read_data(); read_data();

    // long low line gives one zero character: R4
    in_frame = 1'b1;
    rx_serial = 1'b0;
    repeat (20 * 16) step();
    rx_serial = 1'b1;
    repeat (32) step();
    model_push(11'h400);
    in_frame = 1'b0; quiet = 1;
    repeat (2) step();
    one_char(8'h5A, 0, 1);
    read_status(); read_data(); read_data();

    // flags wait for the read end: R8 R10 R9
    cfg_par_en = 1'b1; cfg_par_even = 1'b1;
    one_char(8'h11, 0, 1);
    one_char(8'h22, 1, 1);
    one_char(8'h33, 0, 1);
    read_status();
    read_data();
    read_status();
    read_data();
    read_data();

    // fill past 16 entries: R6
    cfg_par_en = 1'b0;
    for (int i = 0; i < 17; i++) one_char(8'(i * 7 + 1), 0, 1);
    read_status();
    for (int i = 0; i < 16; i++) read_data();

    // legacy forces single register, no queue error bit: R7 R10
    cfg_legacy = 1'b1; cfg_par_en = 1'b1;
    one_char(8'h44, 1, 1);
    one_char(8'h45, 0, 1);
    read_status(); read_data();
    cfg_legacy = 1'b0;

    // transmitter levels: R11
    tx_hold_empty = 1'b0; tx_shift_idle = 1'b1; repeat (2) step();
    tx_hold_empty = 1'b1; tx_shift_idle = 1'b0; repeat (2) step();
    tx_hold_empty = 1'b0; tx_shift_idle = 1'b0; repeat (2) step();
    tx_hold_empty = 1'b1; tx_shift_idle = 1'b1; repeat (2) step();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule